// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Double-Cycle Deselect

This block models a pipelined synchronous static RAM for use inside a larger design or as a behavioural stand-in for an external memory device. Every control, address and data input is captured on the rising clock edge, and read data leaves through an output register one edge after the address was taken. The array is organised as words of four 9-bit byte lanes. Accesses start from either of two address strobes: a processor strobe that is gated by the first chip select, and a controller strobe. Three chip selects decide whether a strobed cycle selects or deselects the device.

Writes are qualified by a global write input, which writes every lane, or by a byte-write enable that lets per-lane selects choose lanes. An internal 2-bit burst counter steps through a group of four words in linear or interleaved order, chosen by a static order input. The data bus is modelled as a value plus a drive flag. The flag follows double-cycle deselect timing and is gated by an asynchronous, active-low output enable.

Top module: `sram_dcd_pipe`

## Requirements
- R1: During and after a synchronous active-high reset, and before any access, `drive` is 0 and `rdata` is all zeros.
- R2: A strobe edge (`cstrb_n` low, or `pstrb_n` low with `cs1_n` low) with all selects active (`cs1_n`=0, `cs2`=1, `cs3_n`=0) and `gw_n`=`bwe_n`=1 reads the addressed word. The word appears on `rdata` after the next rising edge.
- R3: Reads at consecutive edges return each word one edge after its own address was captured.
- R4: `gw_n` low writes all four lanes with `wdata`, whatever `bwe_n` and `bsel_n` hold.
- R5: With `gw_n` high and `bwe_n` low, lane i (`wdata[9i+8:9i]`) is written only when `bsel_n[i]` is 0. Other lanes keep their old contents.
- R6: A `pstrb_n` start is always a read, and write controls present at that edge are ignored. Write controls at the next non-strobe edge write that cycle's `wdata` to the captured address.
- R7: `pstrb_n` has no effect while `cs1_n` is high. The device keeps its selected state and keeps reading its current burst address.
- R8: After an edge that selects the device from the deselected state, `drive` stays 0 for that cycle.
- R9: After an edge that deselects the device (strobe with selects inactive), `drive` stays 1 for one more cycle and is 0 after the following edge.
- R10: `oe_n` high forces `drive` to 0 and `rdata` to zero at once, without waiting for a clock edge.
- R11: With `burst_lin`=1, each non-strobe edge with `adv_n` low moves the low two address bits to base+1, +2, +3 modulo 4. The upper bits are fixed.
- R12: With `burst_lin`=0, the low two address bits follow base XOR count for count 1, 2, 3.
- R13: A `cstrb_n` start with selects active and write controls asserted writes `wdata` to the address given at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_lin | input | 1 | Static burst order: 1 linear, 0 interleaved |
| addr | input | AW | Word address |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane write selects, active low |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| drive | output | 1 | Bus drive flag standing in for tri-state |

## Verification
The bench uses the default parameters: an 8-bit address (256 words) and four 9-bit lanes. The shallow array lets a four-word burst group be filled with distinct words, so both burst orders show up as different data. Each lane gets its own 9-bit pattern, so a write to the wrong lane or a missed global-write override changes a visible field. The default lane count also matches the four select bits that the partial-write and processor-strobe write cases exercise.

// File: rtl/sram_dcd_pkg.sv
package sram_dcd_pkg;

  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } burst_ord_e;

  // Low two address bits for a given burst base and step count.
  function automatic logic [1:0] burst_low(input burst_ord_e ord,
                                           input logic [1:0] base,
                                           input logic [1:0] cnt);
    if (ord == ORD_LINEAR) burst_low = base + cnt;
    else                   burst_low = base ^ cnt;
  endfunction

endpackage

// File: rtl/sram_dcd_decode.sv
module sram_dcd_decode #(
  parameter int LANES = 4
) (
  input  logic             pstrb_n,
  input  logic             cstrb_n,
  input  logic             adv_n,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  input  logic             act_q,
  output logic             start,
  output logic             sel,
  output logic             load,
  output logic             adv,
  output logic             acc_valid,
  output logic             acc_write,
  output logic [LANES-1:0] mask
);

  logic pstrb_ok;
  logic wr_req;

  always_comb begin
    pstrb_ok = !pstrb_n && !cs1_n;
    sel      = !cs1_n && cs2 && !cs3_n;
    start    = pstrb_ok || !cstrb_n;
    wr_req   = !gw_n || !bwe_n;
    load     = start && sel;
    adv      = !start && act_q && !adv_n;
    if (start) begin
      acc_valid = sel;
      acc_write = sel && !pstrb_ok && wr_req;
    end else begin
      acc_valid = act_q;
      acc_write = act_q && wr_req;
    end
    if (!gw_n)       mask = '1;
    else if (!bwe_n) mask = ~bsel_n;
    else             mask = '0;
  end

endmodule

// File: rtl/sram_dcd_burst.sv
module sram_dcd_burst
  import sram_dcd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lin,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic          adv,
  output logic [AW-1:0] acc_addr
);

  logic [AW-1:0] base_q;
  logic [1:0]    step_q;
  logic [1:0]    step_nx;
  burst_ord_e    ord;

  always_comb begin
    ord      = burst_ord_e'(lin);
    step_nx  = adv ? step_q + 2'd1 : step_q;
    acc_addr = load ? ld_addr
                    : {base_q[AW-1:2], burst_low(ord, base_q[1:0], step_nx)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      step_q <= '0;
    end else if (load) begin
      base_q <= ld_addr;
      step_q <= '0;
    end else begin
      step_q <= step_nx;
    end
  end

endmodule

// File: rtl/sram_dcd_array.sv
module sram_dcd_array #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_valid,
  input  logic                    acc_write,
  input  logic [AW-1:0]           acc_addr,
  input  logic [LANES-1:0]        mask,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] dout
);

  localparam int DEPTH = 1 << AW;
  localparam int DW    = LANES * LANE_W;

  logic [AW-1:0]    a_q;
  logic             rd_q;
  logic             wr_q;
  logic [LANES-1:0] wm_q;
  logic [DW-1:0]    wd_q;

  // Input register stage: everything the array needs is captured here.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= acc_valid && !acc_write;
      wr_q <= acc_valid && acc_write;
    end
    a_q  <= acc_addr;
    wm_q <= mask;
    wd_q <= wdata;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_q && wm_q[g]) mem[a_q] <= wd_q[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rst)       lane_q <= '0;
      else if (rd_q) lane_q <= mem[a_q];
    end

    assign dout[g*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/sram_dcd_drive.sv
module sram_dcd_drive (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic sel,
  input  logic oe_n,
  output logic act_q,
  output logic drv_en,
  output logic drive
);

  // act_q: device selected after the last strobed edge.
  // drv_en trails act_q by one edge, which gives both the quiet first
  // cycle after selection and the extra driven cycle after deselection.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      drv_en <= 1'b0;
    end else begin
      if (start) act_q <= sel;
      drv_en <= act_q;
    end
  end

  assign drive = drv_en && !oe_n;

endmodule

// File: rtl/sram_dcd_pipe.sv
module sram_dcd_pipe #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    burst_lin,
  input  logic [AW-1:0]           addr,
  input  logic                    pstrb_n,
  input  logic                    cstrb_n,
  input  logic                    adv_n,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    drive
);

  localparam int DW = LANES * LANE_W;

  logic             start;
  logic             sel;
  logic             load;
  logic             adv;
  logic             acc_valid;
  logic             acc_write;
  logic [LANES-1:0] mask;
  logic [AW-1:0]    acc_addr;
  logic [DW-1:0]    dout;
  logic             act_q;
  logic             drv_en;

  sram_dcd_decode #(.LANES(LANES)) u_dec (
    .pstrb_n  (pstrb_n),
    .cstrb_n  (cstrb_n),
    .adv_n    (adv_n),
    .cs1_n    (cs1_n),
    .cs2      (cs2),
    .cs3_n    (cs3_n),
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .bsel_n   (bsel_n),
    .act_q    (act_q),
    .start    (start),
    .sel      (sel),
    .load     (load),
    .adv      (adv),
    .acc_valid(acc_valid),
    .acc_write(acc_write),
    .mask     (mask)
  );

  sram_dcd_burst #(.AW(AW)) u_burst (
    .clk     (clk),
    .rst     (rst),
    .lin     (burst_lin),
    .load    (load),
    .ld_addr (addr),
    .adv     (adv),
    .acc_addr(acc_addr)
  );

  sram_dcd_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .rst      (rst),
    .acc_valid(acc_valid),
    .acc_write(acc_write),
    .acc_addr (acc_addr),
    .mask     (mask),
    .wdata    (wdata),
    .dout     (dout)
  );

  sram_dcd_drive u_drive (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .sel   (sel),
    .oe_n  (oe_n),
    .act_q (act_q),
    .drv_en(drv_en),
    .drive (drive)
  );

  assign rdata = drive ? dout : '0;

endmodule

// File: rtl/sram_dcd_chk.sv
module sram_dcd_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst,
  input logic          pstrb_n,
  input logic          cstrb_n,
  input logic          cs1_n,
  input logic          oe_n,
  input logic          start,
  input logic          sel,
  input logic          act_q,
  input logic          drv_en,
  input logic          drive,
  input logic          acc_write,
  input logic [DW-1:0] rdata
);

  p_quiet_bus_r1: assert property (@(posedge clk) disable iff (rst)
    !drive |-> (rdata == '0));

  p_pstrb_read_r6: assert property (@(posedge clk) disable iff (rst)
    (!pstrb_n && !cs1_n) |-> !acc_write);

  p_pstrb_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (!pstrb_n && cs1_n && cstrb_n) |=> $stable(act_q));

  p_first_off_r8: assert property (@(posedge clk) disable iff (rst)
    (start && sel && !act_q) |=> (act_q && !drv_en));

  p_dcd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !sel && act_q) |=> (!act_q && drv_en) ##1 !drv_en);

  p_oe_gate_r10: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !drive);

endmodule

bind sram_dcd_pipe sram_dcd_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pstrb_n  (pstrb_n),
  .cstrb_n  (cstrb_n),
  .cs1_n    (cs1_n),
  .oe_n     (oe_n),
  .start    (start),
  .sel      (sel),
  .act_q    (act_q),
  .drv_en   (drv_en),
  .drive    (drive),
  .acc_write(acc_write),
  .rdata    (rdata)
);

// File: tb/sram_dcd_pipe_tb.sv
`timescale 1ns/1ps
module sram_dcd_pipe_tb;

  localparam int AW = 8;
  localparam int LANES = 4;
  localparam int LANE_W = 9;
  localparam int DW = LANES * LANE_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             burst_lin = 1'b1;
  logic [AW-1:0]    addr = '0;
  logic             pstrb_n = 1'b1;
  logic             cstrb_n = 1'b1;
  logic             adv_n = 1'b1;
  logic             cs1_n = 1'b0;
  logic             cs2 = 1'b1;
  logic             cs3_n = 1'b0;
  logic             gw_n = 1'b1;
  logic             bwe_n = 1'b1;
  logic [LANES-1:0] bsel_n = '1;
  logic [DW-1:0]    wdata = '0;
  logic             oe_n = 1'b0;
  logic [DW-1:0]    rdata;
  logic             drive;

  logic [DW-1:0] model [1 << AW];
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  sram_dcd_pipe #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
    .clk(clk), .rst(rst), .burst_lin(burst_lin), .addr(addr),
    .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .wdata(wdata),
    .oe_n(oe_n), .rdata(rdata), .drive(drive)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    pstrb_n = 1'b1; cstrb_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bsel_n = '1;
    cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    logic [DW-1:0] v;
    for (int i = 0; i < LANES; i++)
      v[i*LANE_W +: LANE_W] = LANE_W'((a * 7 + salt * 13 + i * 61 + 5) % 509);
    return v;
  endfunction

  // R13: controller-strobe write at the same edge, global write (R4).
  task automatic wr_full(input int a, input logic [DW-1:0] d);
    addr = AW'(a); cstrb_n = 1'b0; gw_n = 1'b0; wdata = d;
    cyc(); idle();
    model[a] = d;
  endtask

  task automatic rd_check(input int a, input bit use_p, input string req);
    addr = AW'(a);
    if (use_p) pstrb_n = 1'b0; else cstrb_n = 1'b0;
    cyc(); idle(); cyc();
    chk(req, rdata, model[a]);
    chk(req, DW'(drive), DW'(1));
  endtask

  task automatic t_reset();
    chk("R1 drive", DW'(drive), '0);
    chk("R1 rdata", rdata, '0);
  endtask

  task automatic t_gw_write();
    wr_full(10, pat(10, 1));
    rd_check(10, 0, "R13 ctrl write then read");
    // R4: global write overrides byte controls with no lane selected
    addr = 8'd11; cstrb_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b0; bsel_n = 4'b1111;
    wdata = pat(11, 2); cyc(); idle();
    model[11] = pat(11, 2);
    rd_check(11, 0, "R4 global write all lanes");
  endtask

  task automatic t_byte_write();
    logic [DW-1:0] y;
    wr_full(20, pat(20, 3));
    y = pat(20, 4);
    addr = 8'd20; cstrb_n = 1'b0; bwe_n = 1'b0; bsel_n = 4'b1010; wdata = y;
    cyc(); idle();
    model[20][0*LANE_W +: LANE_W] = y[0*LANE_W +: LANE_W];
    model[20][2*LANE_W +: LANE_W] = y[2*LANE_W +: LANE_W];
    rd_check(20, 0, "R5 selected lanes only");
  endtask

  task automatic t_proc_read();
    rd_check(10, 1, "R2 processor strobe read");
    rd_check(20, 0, "R2 controller strobe read");
  endtask

  task automatic t_back_to_back();
    wr_full(50, pat(50, 5));
    wr_full(51, pat(51, 6));
    addr = 8'd50; cstrb_n = 1'b0; cyc();
    addr = 8'd51; cyc();
    idle();
    chk("R3 first of pair", rdata, model[50]);
    cyc();
    chk("R3 second of pair", rdata, model[51]);
  endtask

  task automatic t_proc_write();
    logic [DW-1:0] z;
    wr_full(30, pat(30, 7));
    z = pat(30, 8);
    addr = 8'd30; pstrb_n = 1'b0; gw_n = 1'b0; wdata = pat(30, 9);
    cyc();
    pstrb_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b0; bsel_n = 4'b1110; wdata = z;
    cyc(); idle();
    model[30][LANE_W-1:0] = z[LANE_W-1:0];
    rd_check(30, 0, "R6 processor strobe write next cycle");
  endtask

  task automatic t_cs1_ignore();
    wr_full(60, pat(60, 10));
    wr_full(70, pat(70, 11));
    rd_check(60, 0, "R7 setup");
    addr = 8'd70; pstrb_n = 1'b0; cs1_n = 1'b1;
    cyc(); idle(); cyc();
    chk("R7 data kept", rdata, model[60]);
    cyc();
    chk("R7 still driving", DW'(drive), DW'(1));
    chk("R7 still same word", rdata, model[60]);
  endtask

  task automatic t_dcd();
    cstrb_n = 1'b0; cs2 = 1'b0; cyc(); idle(); cyc(); cyc();
    chk("R9 idle after deselect", DW'(drive), '0);
    addr = 8'd60; cstrb_n = 1'b0; cyc(); idle();
    chk("R8 first cycle off", DW'(drive), '0);
    cyc();
    chk("R8 then driving", DW'(drive), DW'(1));
    chk("R8 data", rdata, model[60]);
    cstrb_n = 1'b0; cs2 = 1'b0; cyc(); idle();
    chk("R9 drives one more cycle", DW'(drive), DW'(1));
    chk("R9 data kept", rdata, model[60]);
    cyc();
    chk("R9 off after next edge", DW'(drive), '0);
    chk("R9 bus quiet", rdata, '0);
  endtask

  task automatic t_oe();
    rd_check(10, 0, "R10 setup");
    #1 oe_n = 1'b1; #1;
    chk("R10 drive gated", DW'(drive), '0);
    chk("R10 rdata zero", rdata, '0);
    oe_n = 1'b0; #1;
    chk("R10 restored", rdata, model[10]);
    cyc();
  endtask

  task automatic t_burst(input bit lin, input int base, input string req);
    int g;
    g = base & ~3;
    burst_lin = lin;
    for (int i = 0; i < 4; i++) wr_full(g + i, pat(g + i, 20 + i));
    addr = AW'(base); cstrb_n = 1'b0; cyc(); idle(); adv_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      int lo;
      if (k == 3) adv_n = 1'b1;
      cyc();
      lo = lin ? ((base + k) & 3) : ((base & 3) ^ k);
      chk(req, rdata, model[g + lo]);
    end
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) cyc();
    t_reset();
    rst = 1'b0;
    cyc();
    t_reset();
    t_gw_write();
    t_byte_write();
    t_proc_read();
    t_back_to_back();
    t_proc_write();
    t_cs1_ignore();
    t_dcd();
    t_oe();
    t_burst(1'b1, 42, "R11 linear burst");
    t_burst(1'b0, 41, "R12 interleaved burst");
    t_burst(1'b0, 255, "R12 interleaved top group");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule